// File: doc/BRIEF.md
# Stop-Exit Clock Sequencer

This block decides how a small processor core comes back from its low-power stop state and which oscillator clocks it afterwards. Software raises a stop request while the core runs. The core is then held until a wake event arrives. A wake caused by the external reset pin or by power-on reset ends in a full reset request. A wake caused by an external interrupt or a time-of-day alarm ends in a resume indication, so the core continues with the instruction after the one that stopped it. In both cases the core is released a fixed number of ring-oscillator cycles after the wake event is sampled.

The block itself runs on the ring oscillator, which is `clk`. The high-frequency oscillator is modelled by an enable output and a tick input that pulses once for each of its edges. The 32kHz source is modelled by a single status input that says it is running. When the high-frequency source is chosen, the core restarts on the ring clock. The block counts the high-frequency warm-up and then moves to that clock through a dead gap, so the clock never glitches. A status output reports the active source, and software can poll it until the handover is done.

Top module: `wk_seq`

## Requirements
- R1: After synchronous reset, `core_run_o` is 1, `clk_sel_o` is 3'b001 (ring), `act_src_o` is 0 (ring) and neither `full_rst_req_o` nor `resume_o` is high.
- R2: A stop request sampled while running drops `core_run_o` and `hf_en_o` after that edge and puts `clk_sel_o` on ring (3'b001). The select stays on ring for as long as the core is held.
- R3: A wake by external reset or power-on reset, sampled while stopped, raises `core_run_o` together with a one-cycle `full_rst_req_o` pulse exactly WAKE_CYC clock edges after the sampling edge.
- R4: A wake by external interrupt or alarm, sampled while stopped, raises `core_run_o` together with a one-cycle `resume_o` pulse with the same WAKE_CYC timing.
- R5: When reset-type and interrupt-type wakes are sampled on the same edge, only the full reset request is produced.
- R6: Wake events that arrive during the wake delay, or while the core is running, produce no extra pulse and do not change `core_run_o`.
- R7: With `src_sel_i` = 2'b01 (ring), the clock select stays on ring after wake.
- R8: With `src_sel_i` = 2'b00 (high-frequency), the core restarts on ring. `hf_en_o` rises one cycle after `core_run_o`. After WARM_CNT high-frequency ticks, `clk_sel_o` goes to 3'b000 for SYNC_EDGES ticks and then to 3'b010.
- R9: With `src_sel_i` = 2'b10 (32kHz), `clk_sel_o` becomes 3'b100 in the same cycle that `core_run_o` rises, provided `lf_ok_i` is 1. If `lf_ok_i` is 0, it stays on ring.
- R10: A stop request during the warm-up cancels the pending handover. A stop request while on the high-frequency clock returns the select to ring after that edge.
- R11: `act_src_o` encodes the active source: 0 ring, 1 high-frequency, 2 32kHz, 3 switching (select gap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_i | input | 1 | Request to enter stop |
| wake_ext_rst_i | input | 1 | Wake by external reset pin |
| wake_por_i | input | 1 | Wake by power-on reset |
| wake_irq_i | input | 1 | Wake by external interrupt |
| wake_alarm_i | input | 1 | Wake by time-of-day alarm |
| src_sel_i | input | 2 | Chosen source: 00 high-frequency, 01 ring, 10 32kHz, 11 ring |
| lf_ok_i | input | 1 | 32kHz amplifier or external 32kHz clock present |
| hf_tick_i | input | 1 | One pulse per high-frequency oscillator edge |
| core_run_o | output | 1 | 1 = core runs, 0 = core held |
| full_rst_req_o | output | 1 | One-cycle pulse: start a normal reset cycle |
| resume_o | output | 1 | One-cycle pulse: resume after the stop instruction |
| hf_en_o | output | 1 | High-frequency oscillator enable |
| clk_sel_o | output | 3 | One-hot select: bit0 ring, bit1 high-frequency, bit2 32kHz |
| act_src_o | output | 2 | Active source status |

## Verification
The bench builds the block with WAKE_CYC = 4, WARM_CNT = 8 and SYNC_EDGES = 2, and drives one high-frequency tick every cycle. With a warm-up of only eight ticks, the whole run on the ring clock, the dead gap and the move to the high-frequency select all fit in a few dozen cycles. This makes it possible to sample each stage at its exact cycle. It also makes it possible to land a stop request in the middle of the warm-up and show that the handover is cancelled.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [1:0] {
    SRC_HF   = 2'b00,
    SRC_RING = 2'b01,
    SRC_LF   = 2'b10,
    SRC_RSV  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    WS_RUN,
    WS_STOP,
    WS_WAKE
  } wk_state_e;

  typedef enum logic [1:0] {
    SW_RING,
    SW_GAP,
    SW_HF,
    SW_LF
  } sw_state_e;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_NONE = 3'b000;
  localparam logic [SEL_W-1:0] SEL_RING = 3'b001;
  localparam logic [SEL_W-1:0] SEL_HF   = 3'b010;
  localparam logic [SEL_W-1:0] SEL_LF   = 3'b100;

  localparam logic [1:0] ACT_RING   = 2'd0;
  localparam logic [1:0] ACT_HF     = 2'd1;
  localparam logic [1:0] ACT_LF     = 2'd2;
  localparam logic [1:0] ACT_SWITCH = 2'd3;

endpackage

// File: rtl/wk_wake_ctrl.sv
module wk_wake_ctrl
  import wk_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic rst_wake,
  input  logic int_wake,
  output logic core_run_o,
  output logic full_rst_o,
  output logic resume_o,
  output logic running_o,
  output logic wake_done_o
);

  localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  wk_state_e     state;
  logic [CW-1:0] dly;
  logic          kind_rst;

  assign running_o   = (state == WS_RUN);
  assign wake_done_o = (state == WS_WAKE) && (dly == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_RUN;
      dly        <= '0;
      kind_rst   <= 1'b0;
      core_run_o <= 1'b1;
      full_rst_o <= 1'b0;
      resume_o   <= 1'b0;
    end else begin
      full_rst_o <= 1'b0;
      resume_o   <= 1'b0;
      case (state)
        WS_RUN: begin
          if (stop_req) begin
            state      <= WS_STOP;
            core_run_o <= 1'b0;
          end
        end
        WS_STOP: begin
          if (rst_wake || int_wake) begin
            state    <= WS_WAKE;
            dly      <= '0;
            kind_rst <= rst_wake;
          end
        end
        WS_WAKE: begin
          if (dly == LAST) begin
            state      <= WS_RUN;
            core_run_o <= 1'b1;
            full_rst_o <= kind_rst;
            resume_o   <= !kind_rst;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        default: state <= WS_RUN;
      endcase
    end
  end

  a_r5_single_outcome: assert property (@(posedge clk) disable iff (rst)
    !(full_rst_o && resume_o));

  a_r3_pulse_on_release: assert property (@(posedge clk) disable iff (rst)
    (full_rst_o || resume_o) |-> (core_run_o && !$past(core_run_o)));

  a_r6_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (state == WS_STOP && !rst_wake && !int_wake) |=> (state == WS_STOP));

  a_r2_held_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (state == WS_STOP) |-> !core_run_o);

endmodule

// File: rtl/wk_warmup.sv
module wk_warmup #(
  parameter int WARM_CNT = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic done_o
);

  localparam int WW = $clog2(WARM_CNT + 1);
  localparam logic [WW-1:0] LAST = WW'(WARM_CNT - 1);

  logic [WW-1:0] cnt;
  logic          fin;

  assign done_o = en && !fin && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      fin <= 1'b0;
    end else if (!fin && tick) begin
      if (cnt == LAST) fin <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
    (done_o && en) |=> !done_o);

endmodule

// File: rtl/wk_clk_switch.sv
module wk_clk_switch
  import wk_pkg::*;
#(
  parameter int SYNC_EDGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_ring,
  input  logic             go_lf,
  input  logic             go_hf,
  input  logic             hf_tick,
  output logic [SEL_W-1:0] sel_o,
  output logic [1:0]       act_o
);

  localparam int GW = $clog2(SYNC_EDGES + 1);
  localparam logic [GW-1:0] GLAST = GW'(SYNC_EDGES - 1);

  sw_state_e     st;
  logic [GW-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SW_RING;
      sel_o <= SEL_RING;
      act_o <= ACT_RING;
      gcnt  <= '0;
    end else if (go_lf) begin
      st    <= SW_LF;
      sel_o <= SEL_LF;
      act_o <= ACT_LF;
    end else if (force_ring) begin
      st    <= SW_RING;
      sel_o <= SEL_RING;
      act_o <= ACT_RING;
      gcnt  <= '0;
    end else begin
      case (st)
        SW_RING: begin
          if (go_hf) begin
            st    <= SW_GAP;
            sel_o <= SEL_NONE;
            act_o <= ACT_SWITCH;
            gcnt  <= '0;
          end
        end
        SW_GAP: begin
          if (hf_tick) begin
            if (gcnt == GLAST) begin
              st    <= SW_HF;
              sel_o <= SEL_HF;
              act_o <= ACT_HF;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r8_gap_before_hf: assert property (@(posedge clk) disable iff (rst)
    (sel_o == SEL_HF && $past(sel_o) != SEL_HF) |-> ($past(sel_o) == SEL_NONE));

  a_r11_onehot_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

endmodule

// File: rtl/wk_seq.sv
module wk_seq
  import wk_pkg::*;
#(
  parameter int WAKE_CYC   = 4,
  parameter int WARM_CNT   = 65536,
  parameter int SYNC_EDGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req_i,
  input  logic       wake_ext_rst_i,
  input  logic       wake_por_i,
  input  logic       wake_irq_i,
  input  logic       wake_alarm_i,
  input  logic [1:0] src_sel_i,
  input  logic       lf_ok_i,
  input  logic       hf_tick_i,
  output logic       core_run_o,
  output logic       full_rst_req_o,
  output logic       resume_o,
  output logic       hf_en_o,
  output logic [2:0] clk_sel_o,
  output logic [1:0] act_src_o
);

  logic running, wake_done, warm_done;
  logic rst_wake, int_wake, go_lf, force_ring;

  assign rst_wake   = wake_ext_rst_i || wake_por_i;
  assign int_wake   = wake_irq_i || wake_alarm_i;
  assign go_lf      = wake_done && (src_sel_i == SRC_LF) && lf_ok_i;
  assign force_ring = !running || stop_req_i;

  wk_wake_ctrl #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req_i),
    .rst_wake    (rst_wake),
    .int_wake    (int_wake),
    .core_run_o  (core_run_o),
    .full_rst_o  (full_rst_req_o),
    .resume_o    (resume_o),
    .running_o   (running),
    .wake_done_o (wake_done)
  );

  always_ff @(posedge clk) begin
    if (rst) hf_en_o <= 1'b0;
    else     hf_en_o <= running && !stop_req_i && (src_sel_i == SRC_HF);
  end

  wk_warmup #(.WARM_CNT(WARM_CNT)) i_warm (
    .clk    (clk),
    .rst    (rst),
    .en     (hf_en_o),
    .tick   (hf_tick_i),
    .done_o (warm_done)
  );

  wk_clk_switch #(.SYNC_EDGES(SYNC_EDGES)) i_sw (
    .clk        (clk),
    .rst        (rst),
    .force_ring (force_ring),
    .go_lf      (go_lf),
    .go_hf      (warm_done),
    .hf_tick    (hf_tick_i),
    .sel_o      (clk_sel_o),
    .act_o      (act_src_o)
  );

  a_r8_hf_needs_osc: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_o == SEL_HF) |-> hf_en_o);

  a_r2_ring_while_held: assert property (@(posedge clk) disable iff (rst)
    !core_run_o |-> (clk_sel_o == SEL_RING));

  a_r10_no_osc_when_held: assert property (@(posedge clk) disable iff (rst)
    !core_run_o |-> !hf_en_o);

endmodule

// File: tb/test_wk_seq.sv
module test_wk_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE_CYC   = 4;
  localparam int WARM_CNT   = 8;
  localparam int SYNC_EDGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, w_ext = 0, w_por = 0, w_irq = 0, w_alarm = 0;
  logic [1:0] src_sel = 2'b01;
  logic lf_ok = 1'b1, hf_tick = 1'b1;
  logic core_run, full_rst_req, resume, hf_en;
  logic [2:0] clk_sel;
  logic [1:0] act_src;

  int tests = 0, fails = 0, cyc = 0;

  typedef struct { bit is_rst; int due; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wk_seq #(.WAKE_CYC(WAKE_CYC), .WARM_CNT(WARM_CNT), .SYNC_EDGES(SYNC_EDGES)) i_wk_seq (
    .clk(clk), .rst(rst), .stop_req_i(stop_req), .wake_ext_rst_i(w_ext),
    .wake_por_i(w_por), .wake_irq_i(w_irq), .wake_alarm_i(w_alarm),
    .src_sel_i(src_sel), .lf_ok_i(lf_ok), .hf_tick_i(hf_tick),
    .core_run_o(core_run), .full_rst_req_o(full_rst_req), .resume_o(resume),
    .hf_en_o(hf_en), .clk_sel_o(clk_sel), .act_src_o(act_src)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor (R3 R4 R5 R6): pulses must match queued outcomes
  always @(negedge clk) begin
    if (!rst) begin
      if (full_rst_req || resume) begin
        if (sb.size() == 0) begin
          chk(0, "R6", "unexpected wake pulse at cycle", cyc, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(full_rst_req == e.is_rst && resume == !e.is_rst, "R5",
              "wake outcome is_rst", int'(full_rst_req), int'(e.is_rst));
          chk(cyc == e.due, "R3", "release cycle", cyc, e.due);
          chk(core_run, "R4", "core_run with pulse", int'(core_run), 1);
        end
      end else if (sb.size() != 0 && cyc > sb[0].due) begin
        chk(0, "R3", "missing wake pulse due at", cyc, sb[0].due);
        void'(sb.pop_front());
      end
    end
  end

  task automatic do_stop();
    stop_req = 1'b1;
    neg(1);
    stop_req = 1'b0;
  endtask

  // drives at a negedge; expected release is seen at the negedge after
  // edge E0 (sample) plus WAKE_CYC edges
  task automatic do_wake(input bit ext, input bit por, input bit irq, input bit alm);
    exp_t e;
    e.is_rst = ext | por;
    e.due    = cyc + 1 + WAKE_CYC;
    sb.push_back(e);
    w_ext = ext; w_por = por; w_irq = irq; w_alarm = alm;
    neg(1);
    w_ext = 0; w_por = 0; w_irq = 0; w_alarm = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "R1", "watchdog expired at cycle", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    neg(3);
    rst = 1'b0;
    neg(1);
    // R1 reset state
    chk(core_run == 1, "R1", "core_run", int'(core_run), 1);
    chk(clk_sel == 3'b001, "R1", "clk_sel", int'(clk_sel), 1);
    chk(act_src == 2'd0, "R1", "act_src", int'(act_src), 0);
    chk(!full_rst_req && !resume, "R1", "pulses", int'(full_rst_req | resume), 0);

    // R2 stop
    do_stop();
    chk(core_run == 0, "R2", "core_run after stop", int'(core_run), 0);
    chk(clk_sel == 3'b001, "R2", "clk_sel after stop", int'(clk_sel), 1);
    chk(hf_en == 0, "R2", "hf_en after stop", int'(hf_en), 0);
    neg(3);
    chk(core_run == 0, "R2", "core_run held", int'(core_run), 0);

    // R4 interrupt wake, R7 ring source
    do_wake(0, 0, 1, 0);
    neg(WAKE_CYC - 1);
    chk(core_run == 0, "R4", "core_run one cycle early", int'(core_run), 0);
    neg(1);
    chk(core_run == 1, "R4", "core_run released", int'(core_run), 1);
    neg(10);
    chk(clk_sel == 3'b001, "R7", "ring stays", int'(clk_sel), 1);

    // R3 power-on reset wake
    do_stop();
    do_wake(0, 1, 0, 0);
    neg(WAKE_CYC + 2);
    // R3 external reset wake
    do_stop();
    do_wake(1, 0, 0, 0);
    neg(WAKE_CYC + 2);

    // R5 simultaneous reset-type and interrupt-type wake
    do_stop();
    do_wake(1, 0, 1, 0);
    neg(WAKE_CYC + 2);

    // R6 wake during delay absorbed
    do_stop();
    do_wake(0, 0, 0, 1);
    w_por = 1'b1;
    neg(1);
    w_por = 1'b0;
    neg(WAKE_CYC + 4);
    chk(core_run == 1, "R6", "core_run after absorbed wake", int'(core_run), 1);
    // R6 wake inputs while running
    w_irq = 1'b1; w_ext = 1'b1;
    neg(1);
    w_irq = 1'b0; w_ext = 1'b0;
    neg(WAKE_CYC + 3);
    chk(core_run == 1, "R6", "core_run after wake in run", int'(core_run), 1);

    // R8 high-frequency handover
    do_stop();
    src_sel = 2'b00;
    neg(2);
    do_wake(0, 0, 1, 0);
    neg(WAKE_CYC);
    chk(clk_sel == 3'b001, "R8", "ring at release", int'(clk_sel), 1);
    chk(hf_en == 0, "R8", "hf_en at release", int'(hf_en), 0);
    neg(1);
    chk(hf_en == 1, "R8", "hf_en one cycle later", int'(hf_en), 1);
    neg(WARM_CNT - 1);
    chk(clk_sel == 3'b001, "R8", "still ring before warm end", int'(clk_sel), 1);
    neg(1);
    chk(clk_sel == 3'b000, "R8", "select gap", int'(clk_sel), 0);
    chk(act_src == 2'd3, "R11", "switching status", int'(act_src), 3);
    neg(SYNC_EDGES - 1);
    chk(clk_sel == 3'b000, "R8", "gap held", int'(clk_sel), 0);
    neg(1);
    chk(clk_sel == 3'b010, "R8", "hf selected", int'(clk_sel), 2);
    chk(act_src == 2'd1, "R11", "hf status", int'(act_src), 1);

    // R10 stop while on hf
    do_stop();
    chk(clk_sel == 3'b001, "R10", "ring after stop on hf", int'(clk_sel), 1);
    chk(act_src == 2'd0, "R11", "ring status", int'(act_src), 0);

    // R10 stop during warm-up cancels handover
    do_wake(0, 0, 1, 0);
    neg(WAKE_CYC + 4);
    chk(hf_en == 1, "R10", "warm-up running", int'(hf_en), 1);
    do_stop();
    chk(hf_en == 0, "R10", "hf_en cancelled", int'(hf_en), 0);
    neg(WARM_CNT + 6);
    chk(clk_sel == 3'b001, "R10", "no switch while held", int'(clk_sel), 1);
    src_sel = 2'b01;
    do_wake(0, 0, 1, 0);
    neg(WAKE_CYC + WARM_CNT + SYNC_EDGES + 6);
    chk(clk_sel == 3'b001, "R10", "ring after cancel", int'(clk_sel), 1);

    // R9 32kHz source direct
    do_stop();
    src_sel = 2'b10;
    lf_ok = 1'b1;
    do_wake(0, 0, 0, 1);
    neg(WAKE_CYC - 1);
    chk(clk_sel == 3'b001, "R9", "ring before release", int'(clk_sel), 1);
    neg(1);
    chk(clk_sel == 3'b100, "R9", "lf at release", int'(clk_sel), 4);
    chk(act_src == 2'd2, "R11", "lf status", int'(act_src), 2);
    chk(core_run == 1, "R9", "core_run with lf", int'(core_run), 1);

    // R9 32kHz not running
    do_stop();
    lf_ok = 1'b0;
    do_wake(0, 0, 1, 0);
    neg(WAKE_CYC + 3);
    chk(clk_sel == 3'b001, "R9", "ring when lf absent", int'(clk_sel), 1);
    chk(act_src == 2'd0, "R11", "ring status lf absent", int'(act_src), 0);

    neg(5);
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule